// File: doc/BRIEF.md
# Branch and Loop Next-PC Unit

This unit decides where execution goes after a relative control-transfer instruction has been decoded. The decoder hands it the sequential program counter, a displacement already sign-extended to the address width, a 4-bit condition code, the four arithmetic flags, the loop counter register, and the instruction class. One cycle later the unit presents the next program counter, whether the transfer was taken, and the new counter value with a write strobe for the register file.

Three classes are handled. A conditional branch tests one of sixteen conditions: two constants plus fourteen signed and unsigned flag tests. An unconditional branch always jumps. The decrement-and-branch loop form exits at once when its condition holds. Otherwise it counts down the low word of the counter and jumps back until that word wraps to all ones. Jump targets are always the sequential PC plus the displacement, modulo the address width.

Top module: `branch_loop_unit`

## Requirements
- R1: `cond_i` selects the condition, with flags_i = {N,Z,V,C} (bit 3 down to bit 0): 0 true, 1 false, 2 HI (!C&!Z), 3 LS (C|Z), 4 CC (!C), 5 CS (C), 6 NE (!Z), 7 EQ (Z), 8 VC (!V), 9 VS (V), 10 PL (!N), 11 MI (N), 12 GE (N==V), 13 LT (N!=V), 14 GT (!Z&(N==V)), 15 LE (Z|(N!=V)).
- R2: With op_i=0 (conditional branch), a true condition gives taken_o=1 and next_pc_o=pc_i+disp_i. A false condition gives taken_o=0 and next_pc_o=pc_i. For example, 0x200 with disp 0x20 and EQ with Z=1 goes to 0x220.
- R3: With op_i=1 (unconditional branch), taken_o=1 and next_pc_o=pc_i+disp_i for any cond_i and flags. For example, 0x200 with disp 0x40 goes to 0x240.
- R4: With op_i=2 (loop) and a true condition, cnt_we_o=0, taken_o=0 and next_pc_o=pc_i.
- R5: With op_i=2 and a false condition, cnt_we_o=1 and the low 16 bits of cnt_o equal the low 16 bits of cnt_i minus 1. When that result is not 0xFFFF, taken_o=1 and next_pc_o=pc_i+disp_i. For example, counter 0x3002 with PC 0x2006 and disp -4 gives counter 0x3001 and target 0x2002.
- R6: With op_i=2 and a false condition, a low word of 0x0000 becomes 0xFFFF with cnt_we_o=1, taken_o=0 and next_pc_o=pc_i.
- R7: The upper 16 bits of cnt_o always equal those of cnt_i.
- R8: Loop mode with code 1 (false) runs a counted loop. Starting from low word k, it is taken k times in a row and falls through on pass k+1.
- R9: Outputs are registered and appear the cycle after valid_i. After reset, and in any cycle without a valid input the cycle before, valid_o, taken_o and cnt_we_o are 0.
- R10: op_i=3 is reserved. It gives taken_o=0, cnt_we_o=0 and next_pc_o=pc_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Inputs carry an instruction this cycle |
| op_i | input | 2 | Class: 0 conditional, 1 unconditional, 2 loop, 3 reserved |
| cond_i | input | 4 | Condition code, encoding in R1 |
| flags_i | input | 4 | {N,Z,V,C} |
| pc_i | input | ADDR_W | Sequential program counter |
| disp_i | input | ADDR_W | Sign-extended displacement |
| cnt_i | input | CNT_W | Loop counter register value |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Transfer taken |
| next_pc_o | output | ADDR_W | Next program counter |
| cnt_o | output | CNT_W | Updated loop counter |
| cnt_we_o | output | 1 | Write strobe for cnt_o |

## Verification
The bench sweeps every condition code against every flag pattern. A swapped signed/unsigned test or a wrong code order would send a branch the wrong way. It drives the loop form through the wrap from 0x0000 to 0xFFFF, where a design that exits on zero instead of on minus one would take one iteration too few or too many. It checks that a true loop condition leaves the counter unwritten, that the upper counter half survives a borrow out of the low word, and that backward displacements wrap the target correctly.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    OP_BCOND   = 2'd0,
    OP_BALWAYS = 2'd1,
    OP_LOOP    = 2'd2,
    OP_RSVD    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    COND_T, COND_F, COND_HI, COND_LS, COND_CC, COND_CS, COND_NE, COND_EQ,
    COND_VC, COND_VS, COND_PL, COND_MI, COND_GE, COND_LT, COND_GT, COND_LE
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       cond_true_o
);
  flags_t f;
  logic   sgn_ge;

  assign f      = flags_t'(flags_i);
  assign sgn_ge = (f.n == f.v);

  always_comb begin
    unique case (cond_e'(cond_i))
      COND_T:  cond_true_o = 1'b1;
      COND_F:  cond_true_o = 1'b0;
      COND_HI: cond_true_o = ~f.c & ~f.z;
      COND_LS: cond_true_o = f.c | f.z;
      COND_CC: cond_true_o = ~f.c;
      COND_CS: cond_true_o = f.c;
      COND_NE: cond_true_o = ~f.z;
      COND_EQ: cond_true_o = f.z;
      COND_VC: cond_true_o = ~f.v;
      COND_VS: cond_true_o = f.v;
      COND_PL: cond_true_o = ~f.n;
      COND_MI: cond_true_o = f.n;
      COND_GE: cond_true_o = sgn_ge;
      COND_LT: cond_true_o = ~sgn_ge;
      COND_GT: cond_true_o = ~f.z & sgn_ge;
      COND_LE: cond_true_o = f.z | ~sgn_ge;
      default: cond_true_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_loop_ctr.sv
module bcu_loop_ctr #(
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dec_en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam int HI_W = CNT_W - LOOP_W;

  logic [LOOP_W-1:0] lo_dec;

  assign lo_dec    = cnt_i[LOOP_W-1:0] - LOOP_W'(1);
  // counter reads -1 after the decrement
  assign expired_o = dec_en_i & (&lo_dec);

  generate
    if (HI_W > 0) begin : g_split
      assign cnt_o = {cnt_i[CNT_W-1:LOOP_W],
                      dec_en_i ? lo_dec : cnt_i[LOOP_W-1:0]};
    end else begin : g_full
      assign cnt_o = dec_en_i ? lo_dec : cnt_i;
    end
  endgenerate
endmodule

// File: rtl/bcu_target.sv
module bcu_target #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] disp_i,
  output logic [ADDR_W-1:0] target_o
);
  assign target_o = pc_i + disp_i;
endmodule

// File: rtl/branch_loop_unit.sv
module branch_loop_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        flags_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] disp_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              valid_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_we_o
);
  op_e               op;
  logic              cond_true;
  logic              dec_en;
  logic              expired;
  logic              take_d;
  logic              we_d;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] pc_d;
  logic [CNT_W-1:0]  cnt_d;

  assign op = op_e'(op_i);

  bcu_cond_eval u_cond (
    .cond_i      (cond_i),
    .flags_i     (flags_i),
    .cond_true_o (cond_true)
  );

  bcu_target #(.ADDR_W(ADDR_W)) u_tgt (
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .target_o (target)
  );

  assign dec_en = (op == OP_LOOP) & ~cond_true;

  bcu_loop_ctr #(.CNT_W(CNT_W), .LOOP_W(LOOP_W)) u_ctr (
    .cnt_i     (cnt_i),
    .dec_en_i  (dec_en),
    .cnt_o     (cnt_d),
    .expired_o (expired)
  );

  always_comb begin
    take_d = 1'b0;
    we_d   = 1'b0;
    unique case (op)
      OP_BCOND:   take_d = cond_true;
      OP_BALWAYS: take_d = 1'b1;
      OP_LOOP: begin
        we_d   = dec_en;
        take_d = dec_en & ~expired;
      end
      default: ;
    endcase
  end

  assign pc_d = take_d ? target : pc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      taken_o   <= 1'b0;
      cnt_we_o  <= 1'b0;
      next_pc_o <= '0;
      cnt_o     <= '0;
    end else begin
      valid_o  <= valid_i;
      taken_o  <= valid_i & take_d;
      cnt_we_o <= valid_i & we_d;
      if (valid_i) begin
        next_pc_o <= pc_d;
        cnt_o     <= cnt_d;
      end
    end
  end
endmodule

// File: rtl/branch_loop_unit_chk.sv
module branch_loop_unit_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int LOOP_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] disp_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              valid_o,
  input logic              taken_o,
  input logic [ADDR_W-1:0] next_pc_o,
  input logic [CNT_W-1:0]  cnt_o,
  input logic              cnt_we_o
);
  AST_TAKEN_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && taken_o) |-> next_pc_o == $past(pc_i + disp_i)); // R2
  AST_FALL_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !taken_o) |-> next_pc_o == $past(pc_i)); // R2
  AST_ALWAYS_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1) |=> taken_o); // R3
  AST_WE_LOOP_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_o |-> $past(op_i) == 2'd2); // R4
  AST_DEC_BY_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_we_o |-> cnt_o[LOOP_W-1:0] == $past(cnt_i[LOOP_W-1:0]) - LOOP_W'(1)); // R5
  AST_EXIT_ON_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_we_o && (&cnt_o[LOOP_W-1:0])) |-> !taken_o); // R6
  AST_UPPER_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> cnt_o[CNT_W-1:LOOP_W] == $past(cnt_i[CNT_W-1:LOOP_W])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (!taken_o && !cnt_we_o)); // R9
  AST_RSVD_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=> (!taken_o && !cnt_we_o)); // R10
endmodule

bind branch_loop_unit branch_loop_unit_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .op_i      (op_i),
  .pc_i      (pc_i),
  .disp_i    (disp_i),
  .cnt_i     (cnt_i),
  .valid_o   (valid_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o),
  .cnt_o     (cnt_o),
  .cnt_we_o  (cnt_we_o)
);

// File: tb/branch_loop_unit_tb_top.sv
module branch_loop_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [3:0]  cond_i = '0;
  logic [3:0]  flags_i = '0;
  logic [31:0] pc_i = '0;
  logic [31:0] disp_i = '0;
  logic [31:0] cnt_i = '0;
  logic        valid_o, taken_o, cnt_we_o;
  logic [31:0] next_pc_o, cnt_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  branch_loop_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .cond_i(cond_i), .flags_i(flags_i), .pc_i(pc_i), .disp_i(disp_i),
    .cnt_i(cnt_i), .valid_o(valid_o), .taken_o(taken_o),
    .next_pc_o(next_pc_o), .cnt_o(cnt_o), .cnt_we_o(cnt_we_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // flags = {N,Z,V,C}
  function automatic bit ref_cond(input int code, input logic [3:0] fl);
    bit n = fl[3], z = fl[2], v = fl[1], c = fl[0];
    case (code)
      0: return 1;          1: return 0;
      2: return !c && !z;   3: return c || z;
      4: return !c;         5: return c;
      6: return !z;         7: return z;
      8: return !v;         9: return v;
      10: return !n;        11: return n;
      12: return n == v;    13: return n != v;
      14: return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

  task automatic apply(input logic [1:0] op, input logic [3:0] cc,
                       input logic [3:0] fl, input logic [31:0] pc,
                       input logic [31:0] disp, input logic [31:0] cnt);
    @(negedge clk_i);
    op_i = op; cond_i = cc; flags_i = fl; pc_i = pc; disp_i = disp; cnt_i = cnt;
    valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9", "reset valid", valid_o, 0);
    chk("R9", "reset taken", taken_o, 0);
    chk("R9", "reset we", cnt_we_o, 0);
    chk("R9", "reset pc", next_pc_o, 0);
  endtask

  task automatic t_cond_sweep;
    for (int c = 0; c < 16; c++) begin
      for (int f = 0; f < 16; f++) begin
        bit e;
        e = ref_cond(c, 4'(f));
        apply(2'd0, 4'(c), 4'(f), 32'h0000_1000, 32'hFFFF_FF80, 32'h0);
        chk("R1", $sformatf("taken c=%0d f=%0h", c, f), taken_o, e);
        chk("R2", $sformatf("pc c=%0d f=%0h", c, f), next_pc_o,
            e ? 32'h0000_0F80 : 32'h0000_1000);
        chk("R9", "valid_o", valid_o, 1);
      end
    end
    // PL equals GE and MI equals LT while V=0
    for (int f = 0; f < 16; f++) begin
      if (f[1] == 1'b0) begin
        chk("R1", "PL==GE", ref_cond(10, 4'(f)), ref_cond(12, 4'(f)));
      end
    end
  endtask

  task automatic t_branch_example;
    apply(2'd0, 4'd7, 4'b0100, 32'h200, 32'h20, 32'h0);
    chk("R2", "eq taken pc", next_pc_o, 32'h220);
    apply(2'd0, 4'd7, 4'b0000, 32'h200, 32'h20, 32'h0);
    chk("R2", "eq not taken pc", next_pc_o, 32'h200);
    chk("R2", "eq not taken flag", taken_o, 0);
  endtask

  task automatic t_always;
    apply(2'd1, 4'd1, 4'b1111, 32'h200, 32'h40, 32'h0);
    chk("R3", "bra taken", taken_o, 1);
    chk("R3", "bra pc", next_pc_o, 32'h240);
    chk("R3", "bra no we", cnt_we_o, 0);
  endtask

  task automatic t_loop_true;
    apply(2'd2, 4'd7, 4'b0100, 32'h500, 32'hFFFF_FFF0, 32'h1234_0007);
    chk("R4", "loop true we", cnt_we_o, 0);
    chk("R4", "loop true taken", taken_o, 0);
    chk("R4", "loop true pc", next_pc_o, 32'h500);
  endtask

  task automatic t_loop_example;
    apply(2'd2, 4'd6, 4'b0100, 32'h2006, 32'hFFFF_FFFC, 32'h0000_3002);
    chk("R5", "loop cnt", cnt_o, 32'h0000_3001);
    chk("R5", "loop we", cnt_we_o, 1);
    chk("R5", "loop taken", taken_o, 1);
    chk("R5", "loop pc", next_pc_o, 32'h2002);
  endtask

  task automatic t_loop_exit;
    apply(2'd2, 4'd1, 4'b0000, 32'h800, 32'hFFFF_FFF8, 32'hABCD_0000);
    chk("R6", "exit we", cnt_we_o, 1);
    chk("R6", "exit taken", taken_o, 0);
    chk("R6", "exit pc", next_pc_o, 32'h800);
    chk("R7", "upper kept on borrow", cnt_o, 32'hABCD_FFFF);
  endtask

  task automatic t_counted;
    logic [31:0] cnt = 32'h5A5A_0003;
    for (int i = 0; i < 4; i++) begin
      apply(2'd2, 4'd1, 4'b0101, 32'h900, 32'hFFFF_FFF4, cnt);
      chk("R8", $sformatf("pass %0d taken", i), taken_o, (i < 3));
      chk("R8", $sformatf("pass %0d pc", i), next_pc_o, (i < 3) ? 32'h8F4 : 32'h900);
      chk("R7", $sformatf("pass %0d upper", i), cnt_o[31:16], 16'h5A5A);
      cnt = cnt_o;
    end
  endtask

  task automatic t_reserved;
    apply(2'd3, 4'd0, 4'b1111, 32'hC00, 32'h100, 32'h0000_0000);
    chk("R10", "rsvd taken", taken_o, 0);
    chk("R10", "rsvd we", cnt_we_o, 0);
    chk("R10", "rsvd pc", next_pc_o, 32'hC00);
  endtask

  task automatic t_idle;
    apply(2'd1, 4'd0, 4'b0000, 32'h10, 32'h10, 32'h0);
    @(negedge clk_i);
    chk("R9", "idle valid", valid_o, 0);
    chk("R9", "idle taken", taken_o, 0);
    chk("R9", "idle we", cnt_we_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_cond_sweep();
    t_branch_example();
    t_always();
    t_loop_true();
    t_loop_example();
    t_loop_exit();
    t_counted();
    t_reserved();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule